// File: doc/BRIEF.md
# Serial Configuration Port for a Three-Loop Frequency Synthesizer

This block is the digital front end that a host uses to set up a synthesizer with one IF loop and two RF loops. The host sends 22-bit words over a three-wire serial link: a clock, a data line and an active-low enable. All three are sampled by the block's system clock. While the enable is low, each rising serial clock edge shifts one data bit into a 22-bit shift register. When the enable rises, the register holds an 18-bit data field and a 4-bit address, and the data field is written to the configuration register that the address selects.

The block decodes the main configuration fields and the three phase detector gain codes. It holds the six divider registers and tracks which RF band is active. The active band is chosen by whichever RF divider register was written last. It also drives power-enable levels for the IF section, the RF section and the reference amplifier. These enables combine the active-low hardware powerdown pin, an auto-powerdown configuration bit and the per-section bits. Every output is a plain register value or a level.

Top module: `synthCfgPort`

## Requirements
- R1: A word is 22 bits sent most significant first: data bits D17..D0, then address bits A3..A0, so the first bit sent ends up as D17 and the last as A0.
- R2: A bit is shifted only on a rising serial clock edge while the enable is low. Serial clock edges while the enable is high change nothing.
- R3: On a rising enable edge, the data field is written to the addressed register. Addresses 3, 4 and 5 are the N dividers for RF1, RF2 and IF. Addresses 6, 7 and 8 are the R dividers for RF1, RF2 and IF. Each divider output shows all 18 data bits.
- R4: A commit to addresses 9 through 15 leaves every output unchanged.
- R5: A write to address 3 or 6 makes `rfBandSel` 0 (RF1). A write to address 4 or 7 makes it 1 (RF2). Writes to any other address leave it unchanged.
- R6: Address 0 fields: auxiliary select is bits 13:12, IF output divide is bits 11:10, reference divide-by-two is bit 6, IF low power is bit 5, auto powerdown is bit 3.
- R7: In address 1, the IF gain is bits 5:4, the RF2 gain is bits 3:2 and the RF1 gain is bits 1:0. In address 2, the IF power bit is bit 1 and the RF power bit is bit 0.
- R8: While `pwdnN` is low, `ifEnable` and `rfEnable` are both 0, whatever the registers hold.
- R9: While `pwdnN` is high, both enables are 1 if auto powerdown is set. Otherwise `ifEnable` follows the IF power bit and `rfEnable` follows the RF power bit.
- R10: `refEnable` is 1 exactly when either section enable is 1. Writes are accepted in every powerdown state.
- R11: After reset, every register and decoded field is 0 and the active band is RF1.
- R12: A commit always uses the last 22 bits shifted. A short word is merged with bits left over from earlier shifts. Extra leading bits in a long word are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial lines |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock |
| sdata | input | 1 | Serial data |
| senN | input | 1 | Active-low serial enable; its rising edge commits the word |
| pwdnN | input | 1 | Active-low hardware powerdown pin |
| auxSel | output | 2 | Auxiliary output select field |
| ifDiv | output | 2 | IF output divide code |
| xinDiv2 | output | 1 | Reference input divide-by-two |
| lowPwr | output | 1 | IF output low-power mode |
| autoPd | output | 1 | Auto powerdown bit |
| kpIf | output | 2 | IF phase detector gain code |
| kpRf2 | output | 2 | RF2 phase detector gain code |
| kpRf1 | output | 2 | RF1 phase detector gain code |
| nRf1 | output | 18 | RF1 N divider |
| nRf2 | output | 18 | RF2 N divider |
| nIf | output | 18 | IF N divider |
| rRf1 | output | 18 | RF1 R divider |
| rRf2 | output | 18 | RF2 R divider |
| rIf | output | 18 | IF R divider |
| rfBandSel | output | 1 | Active RF band, 0 = RF1, 1 = RF2 |
| ifEnable | output | 1 | IF section power enable |
| rfEnable | output | 1 | RF section power enable |
| refEnable | output | 1 | Reference amplifier power enable |

## Verification
The bench sends short words that pick up leftover bits, and long words that carry leading junk. A design that counted bits, or cleared the shift register after a commit, would then write the wrong register or the wrong value. It pulses the serial clock while the enable is high and then commits with no new bits; a port that sampled those pulses would corrupt register 0. It writes reserved addresses with all-ones data, where a decoder that ignored the top address bit would overwrite a real register. It also interleaves writes to every divider register, including the IF ones that must not move the band select. Random changes of the powerdown pin, the auto bit and the section bits expose any wrong priority between the pin and the register bits.

// File: rtl/synthCfgPkg.sv
package synthCfgPkg;

  localparam int WORD_W = 22;
  localparam int ADDR_W = 4;
  localparam int DATA_W = WORD_W - ADDR_W;

  localparam int ADR_MAIN  = 0;
  localparam int ADR_GAIN  = 1;
  localparam int ADR_POWER = 2;
  localparam int ADR_DIV0  = 3;
  localparam int NUM_DIV   = 6;
  localparam int NUM_REGS  = ADR_DIV0 + NUM_DIV;

  localparam int ADR_NRF1 = 3;
  localparam int ADR_NRF2 = 4;
  localparam int ADR_RRF1 = 6;
  localparam int ADR_RRF2 = 7;

  typedef enum logic {BAND_RF1 = 1'b0, BAND_RF2 = 1'b1} bandT;

  typedef struct packed {
    logic [1:0] auxSel;
    logic [1:0] ifDiv;
    logic       xinDiv2;
    logic       lowPwr;
    logic       autoPd;
  } mainCfgT;

  typedef struct packed {
    logic [1:0] kpIf;
    logic [1:0] kpRf2;
    logic [1:0] kpRf1;
  } gainCfgT;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic commitEn;
  } strobeT;

endpackage

// File: rtl/serialCtrl.sv
module serialCtrl
  import synthCfgPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclk,
  input  logic   sdata,
  input  logic   senN,
  output strobeT strobe
);

  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] sclkPipe;
  logic [PIPE_W-1:0] senPipe;
  logic [SYNC_STAGES-1:0] dataPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      senPipe  <= '1;
      dataPipe <= '0;
    end else begin
      sclkPipe <= {sclkPipe[PIPE_W-2:0], sclk};
      senPipe  <= {senPipe[PIPE_W-2:0], senN};
      dataPipe <= {dataPipe[SYNC_STAGES-2:0], sdata};
    end
  end

  logic sclkRise;
  logic senIdle;
  logic senRise;

  always_comb begin
    sclkRise = sclkPipe[SYNC_STAGES-1] & ~sclkPipe[SYNC_STAGES];
    senIdle  = senPipe[SYNC_STAGES-1];
    senRise  = senPipe[SYNC_STAGES-1] & ~senPipe[SYNC_STAGES];
    strobe.shiftEn  = sclkRise & ~senIdle;
    strobe.shiftBit = dataPipe[SYNC_STAGES-1];
    strobe.commitEn = senRise;
  end

  AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    senPipe[SYNC_STAGES-1] |-> !strobe.shiftEn) else $error("shift while idle"); // R2

  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitEn |=> !strobe.commitEn) else $error("double commit"); // R3

endmodule

// File: rtl/cfgDatapath.sv
module cfgDatapath
  import synthCfgPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strobe,
  input  logic                pwdnN,
  output mainCfgT             mainCfg,
  output gainCfgT             gainCfg,
  output logic [DATA_W-1:0]   divOut [NUM_DIV],
  output bandT                band,
  output logic                ifEnable,
  output logic                rfEnable,
  output logic                refEnable
);

  logic [WORD_W-1:0] shiftReg;
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;
  logic              pdIf;
  logic              pdRf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], strobe.shiftBit};
  end

  assign wrAddr = shiftReg[ADDR_W-1:0];
  assign wrData = shiftReg[WORD_W-1:ADDR_W];

  function automatic logic hitAddr(input logic [ADDR_W-1:0] a, input int idx);
    return a == ADDR_W'(idx);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainCfg <= '0;
      gainCfg <= '0;
      pdIf    <= 1'b0;
      pdRf    <= 1'b0;
      band    <= BAND_RF1;
    end else if (strobe.commitEn) begin
      if (hitAddr(wrAddr, ADR_MAIN)) begin
        mainCfg.auxSel  <= wrData[13:12];
        mainCfg.ifDiv   <= wrData[11:10];
        mainCfg.xinDiv2 <= wrData[6];
        mainCfg.lowPwr  <= wrData[5];
        mainCfg.autoPd  <= wrData[3];
      end
      if (hitAddr(wrAddr, ADR_GAIN)) begin
        gainCfg.kpIf  <= wrData[5:4];
        gainCfg.kpRf2 <= wrData[3:2];
        gainCfg.kpRf1 <= wrData[1:0];
      end
      if (hitAddr(wrAddr, ADR_POWER)) begin
        pdIf <= wrData[1];
        pdRf <= wrData[0];
      end
      if (hitAddr(wrAddr, ADR_NRF1) || hitAddr(wrAddr, ADR_RRF1)) band <= BAND_RF1;
      if (hitAddr(wrAddr, ADR_NRF2) || hitAddr(wrAddr, ADR_RRF2)) band <= BAND_RF2;
    end
  end

  for (genvar d = 0; d < NUM_DIV; d++) begin : gDiv
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) divOut[d] <= '0;
      else if (strobe.commitEn && hitAddr(wrAddr, ADR_DIV0 + d)) divOut[d] <= wrData;
    end
  end

  always_comb begin
    ifEnable  = pwdnN & (mainCfg.autoPd | pdIf);
    rfEnable  = pwdnN & (mainCfg.autoPd | pdRf);
    refEnable = ifEnable | rfEnable;
  end

  logic [NUM_DIV*DATA_W-1:0] divFlat;
  for (genvar d = 0; d < NUM_DIV; d++) begin : gFlat
    assign divFlat[d*DATA_W +: DATA_W] = divOut[d];
  end

  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commitEn && wrAddr >= ADDR_W'(NUM_REGS)) |=>
      $stable({divFlat, mainCfg, gainCfg, pdIf, pdRf, band})) else $error("reserved write"); // R4

  AST_BAND_RF1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commitEn && (wrAddr == ADDR_W'(ADR_NRF1) || wrAddr == ADDR_W'(ADR_RRF1))) |=>
      band == BAND_RF1) else $error("band rf1"); // R5

  AST_BAND_RF2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commitEn && (wrAddr == ADDR_W'(ADR_NRF2) || wrAddr == ADDR_W'(ADR_RRF2))) |=>
      band == BAND_RF2) else $error("band rf2"); // R5

  AST_PIN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !pwdnN |-> (!ifEnable && !rfEnable && !refEnable)) else $error("pin off"); // R8

  AST_AUTO_ON: assert property (@(posedge clk) disable iff (!rstN)
    (pwdnN && mainCfg.autoPd) |-> (ifEnable && rfEnable)) else $error("auto on"); // R9

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(shiftReg)) else $error("shift hold"); // R2

endmodule

// File: rtl/synthCfgPort.sv
module synthCfgPort
  import synthCfgPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclk,
  input  logic        sdata,
  input  logic        senN,
  input  logic        pwdnN,
  output logic [1:0]  auxSel,
  output logic [1:0]  ifDiv,
  output logic        xinDiv2,
  output logic        lowPwr,
  output logic        autoPd,
  output logic [1:0]  kpIf,
  output logic [1:0]  kpRf2,
  output logic [1:0]  kpRf1,
  output logic [17:0] nRf1,
  output logic [17:0] nRf2,
  output logic [17:0] nIf,
  output logic [17:0] rRf1,
  output logic [17:0] rRf2,
  output logic [17:0] rIf,
  output logic        rfBandSel,
  output logic        ifEnable,
  output logic        rfEnable,
  output logic        refEnable
);

  strobeT            strobe;
  mainCfgT           mainCfg;
  gainCfgT           gainCfg;
  logic [DATA_W-1:0] divOut [NUM_DIV];
  bandT              band;

  serialCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .sdata(sdata), .senN(senN), .strobe(strobe)
  );

  cfgDatapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pwdnN(pwdnN),
    .mainCfg(mainCfg), .gainCfg(gainCfg), .divOut(divOut), .band(band),
    .ifEnable(ifEnable), .rfEnable(rfEnable), .refEnable(refEnable)
  );

  assign auxSel    = mainCfg.auxSel;
  assign ifDiv     = mainCfg.ifDiv;
  assign xinDiv2   = mainCfg.xinDiv2;
  assign lowPwr    = mainCfg.lowPwr;
  assign autoPd    = mainCfg.autoPd;
  assign kpIf      = gainCfg.kpIf;
  assign kpRf2     = gainCfg.kpRf2;
  assign kpRf1     = gainCfg.kpRf1;
  assign nRf1      = divOut[0];
  assign nRf2      = divOut[1];
  assign nIf       = divOut[2];
  assign rRf1      = divOut[3];
  assign rRf2      = divOut[4];
  assign rIf       = divOut[5];
  assign rfBandSel = band;

endmodule

// File: tb/synthCfgPort_bench.sv
module synthCfgPort_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic sdata = 1'b0;
  logic senN = 1'b1;
  logic pwdnN = 1'b1;

  logic [1:0]  auxSel, ifDiv, kpIf, kpRf2, kpRf1;
  logic        xinDiv2, lowPwr, autoPd, rfBandSel, ifEnable, rfEnable, refEnable;
  logic [17:0] nRf1, nRf2, nIf, rRf1, rRf2, rIf;

  always #5 clk = ~clk;

  synthCfgPort u_synthCfgPort (
    .clk(clk), .rstN(rstN), .sclk(sclk), .sdata(sdata), .senN(senN), .pwdnN(pwdnN),
    .auxSel(auxSel), .ifDiv(ifDiv), .xinDiv2(xinDiv2), .lowPwr(lowPwr), .autoPd(autoPd),
    .kpIf(kpIf), .kpRf2(kpRf2), .kpRf1(kpRf1),
    .nRf1(nRf1), .nRf2(nRf2), .nIf(nIf), .rRf1(rRf1), .rRf2(rRf2), .rIf(rIf),
    .rfBandSel(rfBandSel), .ifEnable(ifEnable), .rfEnable(rfEnable), .refEnable(refEnable)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [21:0] mShift = '0;
  logic [17:0] mReg [9];
  logic        mBand = 1'b0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic expIf();
    return pwdnN & (mReg[0][3] | mReg[2][1]);
  endfunction
  function automatic logic expRf();
    return pwdnN & (mReg[0][3] | mReg[2][0]);
  endfunction

  task automatic checkAll(input string ctx);
    check("R6", {ctx, " auxSel"}, 32'(auxSel), 32'(mReg[0][13:12]));
    check("R6", {ctx, " ifDiv"}, 32'(ifDiv), 32'(mReg[0][11:10]));
    check("R6", {ctx, " xinDiv2"}, 32'(xinDiv2), 32'(mReg[0][6]));
    check("R6", {ctx, " lowPwr"}, 32'(lowPwr), 32'(mReg[0][5]));
    check("R6", {ctx, " autoPd"}, 32'(autoPd), 32'(mReg[0][3]));
    check("R7", {ctx, " gains"}, 32'({kpIf, kpRf2, kpRf1}), 32'(mReg[1][5:0]));
    check("R3", {ctx, " nRf1"}, 32'(nRf1), 32'(mReg[3]));
    check("R3", {ctx, " nRf2"}, 32'(nRf2), 32'(mReg[4]));
    check("R3", {ctx, " nIf"}, 32'(nIf), 32'(mReg[5]));
    check("R3", {ctx, " rRf1"}, 32'(rRf1), 32'(mReg[6]));
    check("R3", {ctx, " rRf2"}, 32'(rRf2), 32'(mReg[7]));
    check("R3", {ctx, " rIf"}, 32'(rIf), 32'(mReg[8]));
    check("R5", {ctx, " band"}, 32'(rfBandSel), 32'(mBand));
    check(pwdnN ? "R9" : "R8", {ctx, " ifEnable"}, 32'(ifEnable), 32'(expIf()));
    check(pwdnN ? "R9" : "R8", {ctx, " rfEnable"}, 32'(rfEnable), 32'(expRf()));
    check("R10", {ctx, " refEnable"}, 32'(refEnable), 32'(expIf() | expRf()));
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseSclk(input logic b);
    sdata = b;
    waitClk(3);
    sclk = 1'b1;
    waitClk(3);
    sclk = 1'b0;
    waitClk(2);
  endtask

  task automatic shiftBit(input logic b);
    pulseSclk(b);
    mShift = {mShift[20:0], b};
  endtask

  task automatic commit();
    logic [3:0] a;
    waitClk(2);
    senN = 1'b1;
    a = mShift[3:0];
    if (a < 4'd9) mReg[a] = mShift[21:4];
    if (a == 4'd3 || a == 4'd6) mBand = 1'b0;
    if (a == 4'd4 || a == 4'd7) mBand = 1'b1;
    waitClk(6);
  endtask

  task automatic sendBits(input logic [63:0] v, input int n);
    senN = 1'b0;
    waitClk(2);
    for (int i = n - 1; i >= 0; i--) shiftBit(v[i]);
    commit();
  endtask

  task automatic sendWord(input logic [17:0] d, input logic [3:0] a);
    sendBits(64'({d, a}), 22);
  endtask

  initial begin
    for (int i = 0; i < 9; i++) mReg[i] = '0;
    void'($urandom(32'd1234));
    waitClk(3);
    rstN = 1'b1;
    waitClk(3);
    checkAll("R11 reset");

    // R1: bit order, N RF1 word then R RF2
    sendWord(18'h2A5C3, 4'd3);
    checkAll("R1 first word");
    sendWord(18'h15A3C, 4'd7);
    checkAll("R5 rf2 via R");

    // R6/R7 field positions
    sendWord(18'h03C68, 4'd0);
    checkAll("R6 main");
    sendWord(18'h0003F, 4'd1);
    checkAll("R7 gain");
    sendWord(18'h00002, 4'd2);
    checkAll("R7 power if only");

    // R8: pin low overrides, port still writable (R10)
    pwdnN = 1'b0;
    waitClk(2);
    checkAll("R8 pin low");
    sendWord(18'h00003, 4'd2);
    sendWord(18'h01234, 4'd5);
    checkAll("R10 write in powerdown");
    pwdnN = 1'b1;
    waitClk(2);
    checkAll("R9 pin high");

    // R4: reserved addresses with all-ones data
    for (int a = 9; a < 16; a++) begin
      sendWord(18'h3FFFF, 4'(a));
      checkAll("R4 reserved");
    end

    // R2: serial clock pulses while idle, then empty commit
    sendWord(18'h0ABCD, 4'd8);
    for (int i = 0; i < 6; i++) pulseSclk(1'b0);
    senN = 1'b0;
    waitClk(4);
    commit();
    checkAll("R2 idle pulses ignored");

    // R12: short word merges with leftover bits, long word drops leading junk
    sendBits(64'h2C6, 10);
    checkAll("R12 short word");
    sendBits({10'h3FF, 18'h0F0F0, 4'd4}, 32);
    checkAll("R12 long word");

    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [17:0] d;
      logic [3:0]  a;
      d = 18'($urandom);
      a = 4'($urandom_range(0, 15));
      pwdnN = 1'($urandom);
      sendWord(d, a);
      checkAll("R3 random");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule